// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Hardware Flow Control

This block is a full-duplex asynchronous serial port. Characters are 5 to 9 bits long. A parity bit, even or odd, may be added, and frames end with one or two stop bits. A single divider sets the bit rate for both directions. It produces one oversampling tick every `cfg_div+1` clocks. A bit lasts 16 ticks, or 8 ticks when double speed is selected.

The host loads a character into a one-word transmit holding register. The transmitter starts a new frame only while `cts` is high. A frame that has already started always runs to its end.

The receiver takes three samples near the middle of every bit and keeps the majority value. This same vote screens the start bit, so a short low glitch on the line is rejected. Received words go into a small FIFO, together with their framing and parity flags. When the FIFO reaches its nominal depth, `rts` is raised two-thirds of the way through the stop bit. The FIFO has one spare slot, so the sender may still finish one more character without loss.

Top module: `uart_rts_xcvr`

## Requirements
- R1: Data bits go out and come in least-significant bit first. The bit count is `cfg_len`+5, where `cfg_len` is 0..4 and values above 4 mean 9 bits. Upper bits of a received word that lie outside the character are read as zero.
- R2: `cfg_par` selects parity. Values 0 and 1 mean no parity. Value 2 means even parity, where the parity bit equals the XOR of the data bits. Value 3 means odd parity, the inverse of that XOR. A received parity bit that does not match sets `pe` for that word.
- R3: The transmitter sends one stop bit, or two stop bits when `cfg_stop2` is 1. A received word whose first stop bit samples low has `fe` set.
- R4: One bit lasts 16·(`cfg_div`+1) clocks. With `cfg_dbl`=1 it lasts 8·(`cfg_div`+1) clocks.
- R5: The start bit is qualified by a majority of three mid-bit samples. A low pulse that leaves two or more of those samples high produces no word, and the receiver goes back to looking for a falling edge.
- R6: The receive FIFO holds DEPTH+1 words (3 by default) and returns them in order. A word that completes while the FIFO is full is dropped and sets `dor`. `dor` clears on the next read.
- R7: `rts` rises at two-thirds of a stop bit when the FIFO then holds DEPTH or more words. It falls as soon as a read leaves fewer than DEPTH words.
- R8: With `cts` low no frame starts and `tx` stays high. A frame that has already started when `cts` falls is completed.
- R9: Driving `rx_en` low flushes the FIFO. After that `rxc`, `rts` and `dor` read 0.
- R10: `dre` falls on a write to the holding register and rises when the transmitter takes the word. `txc` rises when a frame ends with no word pending and clears on the next write.
- R11: After reset `tx`=1, `rts`=0, `dre`=1, `txc`=0, `rxc`=0 and `dor`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 12 | Tick divider; a tick occurs every cfg_div+1 clocks |
| cfg_dbl | input | 1 | Double speed: 8 ticks per bit instead of 16 |
| cfg_len | input | 3 | Character length minus 5 |
| cfg_par | input | 2 | Parity: 0/1 none, 2 even, 3 odd |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the FIFO |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmission complete |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 9 | FIFO head word, zero when empty |
| rxc | output | 1 | FIFO holds at least one word |
| fe | output | 1 | Framing error of the head word |
| pe | output | 1 | Parity error of the head word |
| dor | output | 1 | A word was lost because the FIFO was full |
| tx | output | 1 | Serial output |
| rx | input | 1 | Serial input |
| cts | input | 1 | Clear to send; high allows a new frame |
| rts | output | 1 | Receive buffer full; asks the sender to pause |

## Verification
The hardest state to reach is the edge of the flow-control window. The FIFO has to be filled to its nominal depth, then filled to the spare slot, and then overrun. This must happen without reads, so `rts` can be seen before and after each character.

The bench gets there by looping `tx` back to `rx` and sending four words back to back. After each word's stop bit it samples `rts` and `dor`. It then drains the FIFO one word at a time to see `rts` fall.

Noise rejection and line errors cannot come from the transmitter. For those, the bench drives `rx` itself with short glitches, frames whose stop bit is low, and frames with the wrong parity.

// File: rtl/uart_rts_xcvr.sv
module uart_rts_xcvr #(
  parameter int DIV_W = 12,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_dbl,
  input  logic [2:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_stop2,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  output logic             dre,
  output logic             txc,
  input  logic             rd_en,
  output logic [8:0]       rd_data,
  output logic             rxc,
  output logic             fe,
  output logic             pe,
  output logic             dor,
  output logic             tx,
  input  logic             rx,
  input  logic             cts,
  output logic             rts
);
  localparam int ENTRIES = DEPTH + 1;
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(ENTRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [DIV_W-1:0] bcnt;
  wire tick = (bcnt >= cfg_div);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? '0 : bcnt + 1'b1;

  wire [3:0] os_last = cfg_dbl ? 4'd7 : 4'd15;
  wire [3:0] smp_mid = cfg_dbl ? 4'd4 : 4'd8;
  wire [3:0] rts_pt  = cfg_dbl ? 4'd5 : 4'd10;
  wire [3:0] nbits   = (cfg_len > 3'd4) ? 4'd9 : {1'b0, cfg_len} + 4'd5;

  // receiver
  logic       rx_m, rx_s, rpar, rperr;
  st_t        rst_q;
  logic [3:0] ros, rbit;
  logic [1:0] vcnt;
  logic [8:0] rsh;
  logic [10:0] mem [ENTRIES];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire maj      = (vcnt + {1'b0, rx_s}) >= 2'd2;
  wire vote_pt  = tick && rst_q != S_IDLE && ros == smp_mid + 4'd1;
  wire push     = rx_en && vote_pt && rst_q == S_STOP;
  wire stop_end = tick && rst_q == S_STOP && ros == rts_pt;
  wire full     = cnt == CW'(ENTRIES);
  wire do_push  = push && !full;
  wire pop      = rd_en && cnt != '0;
  wire [CW-1:0] cnt_nxt = cnt + CW'(do_push) - CW'(pop);
  wire [8:0] rword = rsh >> (4'd9 - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rst_q <= S_IDLE; ros <= '0; rbit <= '0;
      vcnt <= '0; rsh <= '0; rpar <= 1'b0; rperr <= 1'b0;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
      if (!rx_en) rst_q <= S_IDLE;
      else if (tick) begin
        if (rst_q == S_IDLE) begin
          if (!rx_s) begin
            rst_q <= S_START; ros <= 4'd1; vcnt <= '0;
            rsh <= '0; rpar <= 1'b0; rperr <= 1'b0;
          end
        end else begin
          if (ros == smp_mid - 4'd1 || ros == smp_mid) vcnt <= vcnt + {1'b0, rx_s};
          if (ros == smp_mid + 4'd1)
            case (rst_q)
              S_START: if (maj) rst_q <= S_IDLE;
              S_DATA:  begin rsh <= {maj, rsh[8:1]}; rpar <= rpar ^ maj; end
              S_PAR:   rperr <= maj ^ rpar ^ cfg_par[0];
              default: ;
            endcase
          if (stop_end) rst_q <= S_IDLE;
          else if (ros == os_last) begin
            ros <= '0; vcnt <= '0;
            case (rst_q)
              S_START: begin rst_q <= S_DATA; rbit <= '0; end
              S_DATA:  if (rbit == nbits - 4'd1) rst_q <= cfg_par[1] ? S_PAR : S_STOP;
                       else rbit <= rbit + 4'd1;
              S_PAR:   rst_q <= S_STOP;
              default: ;
            endcase
          end else ros <= ros + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= {rperr, !maj, rword};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; rts <= 1'b0; dor <= 1'b0;
    end else if (!rx_en) begin
      wp <= '0; rp <= '0; cnt <= '0; rts <= 1'b0; dor <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(ENTRIES - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == PW'(ENTRIES - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt_nxt;
      if (push && full) dor <= 1'b1;
      else if (pop)     dor <= 1'b0;
      if (stop_end && cnt_nxt >= CW'(DEPTH)) rts <= 1'b1;
      else if (cnt_nxt < CW'(DEPTH))         rts <= 1'b0;
    end
  end

  wire [10:0] head = mem[rp];
  assign rxc     = cnt != '0;
  assign rd_data = rxc ? head[8:0] : 9'd0;
  assign fe      = rxc & head[9];
  assign pe      = rxc & head[10];

  // transmitter
  st_t        tst;
  logic [3:0] tos, tbit;
  logic [8:0] tsh, thr;
  logic       tpar;

  assign tx = (tst == S_START) ? 1'b0 :
              (tst == S_DATA)  ? tsh[0] :
              (tst == S_PAR)   ? (tpar ^ cfg_par[0]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst <= S_IDLE; tos <= '0; tbit <= '0; tsh <= '0; tpar <= 1'b0;
      thr <= '0; dre <= 1'b1; txc <= 1'b0;
    end else begin
      if (tick) begin
        if (tst == S_IDLE) begin
          if (!dre && cts && tx_en) begin
            tst <= S_START; tos <= '0; tsh <= thr; tpar <= 1'b0; dre <= 1'b1;
          end
        end else if (tos == os_last) begin
          tos <= '0;
          case (tst)
            S_START: begin tst <= S_DATA; tbit <= '0; end
            S_DATA: begin
              tsh <= tsh >> 1;
              tpar <= tpar ^ tsh[0];
              if (tbit == nbits - 4'd1) begin
                tst <= cfg_par[1] ? S_PAR : S_STOP; tbit <= '0;
              end else tbit <= tbit + 4'd1;
            end
            S_PAR: begin tst <= S_STOP; tbit <= '0; end
            default:
              if (tbit == {3'd0, cfg_stop2}) begin tst <= S_IDLE; txc <= dre; end
              else tbit <= tbit + 4'd1;
          endcase
        end else tos <= tos + 4'd1;
      end
      if (wr_en) begin thr <= wr_data; dre <= 1'b0; txc <= 1'b0; end
    end
  end
endmodule

// File: rtl/uart_rts_xcvr_chk.sv
module uart_rts_xcvr_chk #(
  parameter int DEPTH = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          cts,
  input logic          wr_en,
  input logic          dre,
  input logic          rxc,
  input logic          rts,
  input logic [CW-1:0] cnt,
  input logic [2:0]    tx_state
);
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH + 1));
  p_rts_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> cnt >= CW'(DEPTH));
  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state == 3'd0 && !cts) |=> tx_state == 3'd0);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && !rts));
  p_dre_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dre);
endmodule

bind uart_rts_xcvr uart_rts_xcvr_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cts(cts), .wr_en(wr_en),
  .dre(dre), .rxc(rxc), .rts(rts), .cnt(cnt), .tx_state(tst)
);

// File: tb/uart_rts_xcvr_bench.sv
module uart_rts_xcvr_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [11:0] cfg_div = 12'd1;
  logic cfg_dbl = 1'b0, cfg_stop2 = 1'b0, tx_en = 1'b1, rx_en = 1'b1;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_par = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, cts = 1'b1;
  logic [8:0] wr_data = '0;
  logic dre, txc, rxc, fe, pe, dor, tx, rts;
  logic [8:0] rd_data;
  logic lb = 1'b1, bb = 1'b1;
  wire line = lb ? tx : bb;

  uart_rts_xcvr u_uart_rts_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbl(cfg_dbl),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .tx_en(tx_en), .rx_en(rx_en), .wr_en(wr_en), .wr_data(wr_data),
    .dre(dre), .txc(txc), .rd_en(rd_en), .rd_data(rd_data), .rxc(rxc),
    .fe(fe), .pe(pe), .dor(dor), .tx(tx), .rx(line), .cts(cts), .rts(rts)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [8:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_txc();
    for (int i = 0; i < 6000 && !txc; i++) @(negedge clk);
  endtask

  task automatic wait_rxc();
    for (int i = 0; i < 6000 && !rxc; i++) @(negedge clk);
  endtask

  task automatic read_word(output logic [8:0] d, output logic f, output logic p);
    @(negedge clk); d = rd_data; f = fe; p = pe; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bitbang(input logic [8:0] v, input int nb, input bit par_on,
                         input bit odd, input bit bad_par, input bit stopv);
    int per;
    bit pb;
    per = (cfg_dbl ? 8 : 16) * (int'(cfg_div) + 1);
    pb = 1'b0;
    @(negedge clk); bb = 1'b0; wait_clk(per);
    for (int i = 0; i < nb; i++) begin
      bb = v[i]; pb ^= v[i]; wait_clk(per);
    end
    if (par_on) begin bb = pb ^ odd ^ bad_par; wait_clk(per); end
    bb = stopv; wait_clk(per);
    bb = 1'b1; wait_clk(per);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] d, v;
    logic f, p;
    int cntv;
    bit saw_low;
    logic [8:0] c [4];

    wait_clk(3);
    check(tx === 1'b1 && rts === 1'b0, "R11 tx/rts", {tx, rts}, 2'b10);
    check(dre === 1'b1 && txc === 1'b0, "R11 dre/txc", {dre, txc}, 2'b10);
    check(rxc === 1'b0 && dor === 1'b0, "R11 rxc/dor", {rxc, dor}, 2'b00);
    rst_n = 1'b1;
    wait_clk(2);

    // loopback sweep of all frame formats, both speeds
    for (int len = 0; len < 5; len++)
      for (int pi = 0; pi < 3; pi++)
        for (int s = 0; s < 2; s++)
          for (int db = 0; db < 2; db++) begin
            @(negedge clk);
            cfg_len = 3'(len); cfg_par = (pi == 0) ? 2'd0 : 2'(pi + 1);
            cfg_stop2 = 1'(s); cfg_dbl = 1'(db);
            for (int k = 0; k < 2; k++) begin
              v = 9'((len * 37 + pi * 91 + s * 5 + db * 3 + k * 173 + 85) & 9'h1FF);
              send_word(v);
              wait_rxc();
              read_word(d, f, p);
              check(d === 9'(v & ((1 << (len + 5)) - 1)), "R1 loopback data",
                    d, v & ((1 << (len + 5)) - 1));
              check(f === 1'b0 && p === 1'b0, "R2 no error flags on clean frame",
                    {f, p}, 0);
              wait_txc();
            end
          end

    @(negedge clk);
    cfg_len = 3'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0; cfg_dbl = 1'b0; cfg_div = 12'd1;

    // R10 dre/txc
    send_word(9'h0A5);
    check(dre === 1'b0 && txc === 1'b0, "R10 dre low after write", {dre, txc}, 0);
    wait_txc();
    check(dre === 1'b1 && txc === 1'b1, "R10 dre/txc after frame", {dre, txc}, 3);
    wait_rxc(); read_word(d, f, p);

    // R3 stop bit count: frame length from start edge to txc
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); cfg_stop2 = 1'(s);
      send_word(9'h033);
      while (tx !== 1'b0) @(negedge clk);
      cntv = 0;
      while (!txc) begin @(negedge clk); cntv++; end
      check(cntv == (10 + s) * 32, "R3 frame length", cntv, (10 + s) * 32);
      wait_rxc(); read_word(d, f, p);
    end
    @(negedge clk); cfg_stop2 = 1'b0;

    // R4 bit time normal and double speed
    for (int db = 0; db < 2; db++) begin
      @(negedge clk); cfg_div = 12'd2; cfg_dbl = 1'(db);
      send_word(9'h0FF);
      while (tx !== 1'b0) @(negedge clk);
      cntv = 0;
      while (tx === 1'b0) begin @(negedge clk); cntv++; end
      check(cntv == (db ? 24 : 48), "R4 start bit width", cntv, db ? 24 : 48);
      wait_txc(); wait_rxc(); read_word(d, f, p);
      check(d === 9'h0FF, "R4 data at rate", d, 9'h0FF);
    end
    @(negedge clk); cfg_div = 12'd1; cfg_dbl = 1'b0;

    // R8 CTS gating
    @(negedge clk); cts = 1'b0;
    send_word(9'h05A);
    saw_low = 0;
    for (int i = 0; i < 700; i++) begin @(negedge clk); if (tx === 1'b0) saw_low = 1; end
    check(!saw_low, "R8 no frame while cts low", saw_low, 0);
    check(dre === 1'b0, "R8 word held pending", dre, 0);
    cts = 1'b1;
    wait_rxc(); read_word(d, f, p);
    check(d === 9'h05A, "R8 sent after cts", d, 9'h05A);
    wait_txc();
    send_word(9'h0C3);
    while (tx !== 1'b0) @(negedge clk);
    cts = 1'b0;
    wait_txc();
    check(txc === 1'b1, "R8 frame in progress completes", txc, 1);
    wait_rxc(); read_word(d, f, p);
    check(d === 9'h0C3, "R8 completed frame data", d, 9'h0C3);
    @(negedge clk); cts = 1'b1;

    // R6/R7 fill, RTS, spare slot, overrun
    for (int i = 0; i < 4; i++) c[i] = 9'(8'h11 * (i + 3));
    for (int i = 0; i < 4; i++) begin
      send_word(c[i]); wait_txc(); wait_clk(8);
      if (i == 0) check(rts === 1'b0, "R7 rts low below depth", rts, 0);
      if (i == 1) check(rts === 1'b1 && dor === 1'b0, "R7 rts at depth", {rts, dor}, 2);
      if (i == 2) check(rts === 1'b1 && dor === 1'b0, "R6 spare slot no loss", {rts, dor}, 2);
      if (i == 3) check(dor === 1'b1, "R6 overrun flagged", dor, 1);
    end
    read_word(d, f, p);
    check(d === c[0], "R6 order word0", d, c[0]);
    check(rts === 1'b1 && dor === 1'b0, "R7 rts held at depth, dor cleared", {rts, dor}, 2);
    read_word(d, f, p);
    check(d === c[1], "R6 order word1", d, c[1]);
    check(rts === 1'b0, "R7 rts falls below depth", rts, 0);
    read_word(d, f, p);
    check(d === c[2], "R6 spare word kept", d, c[2]);
    check(rxc === 1'b0, "R6 fifo empty", rxc, 0);

    // R9 flush
    send_word(9'h021); wait_txc();
    send_word(9'h042); wait_txc(); wait_clk(8);
    check(rxc === 1'b1 && rts === 1'b1, "R9 fifo loaded", {rxc, rts}, 3);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    check(rxc === 1'b0 && rts === 1'b0 && dor === 1'b0, "R9 flushed", {rxc, rts, dor}, 0);

    // R5 noise rejection on start bit
    @(negedge clk); lb = 1'b0; bb = 1'b1;
    wait_clk(4); bb = 1'b0; wait_clk(2); bb = 1'b1; wait_clk(600);
    check(rxc === 1'b0, "R5 short glitch rejected", rxc, 0);
    bb = 1'b0; wait_clk(6); bb = 1'b1; wait_clk(600);
    check(rxc === 1'b0, "R5 early-only glitch rejected", rxc, 0);
    bitbang(9'h096, 8, 0, 0, 0, 1);
    wait_rxc(); read_word(d, f, p);
    check(d === 9'h096 && f === 1'b0, "R5 resumes after glitch", d, 9'h096);

    // R3 framing error
    bitbang(9'h03C, 8, 0, 0, 0, 0);
    wait_rxc(); read_word(d, f, p);
    check(f === 1'b1 && d === 9'h03C, "R3 fe on low stop", {f, d}, {1'b1, 9'h03C});
    wait_clk(100);

    // R2 parity checking, even and odd
    for (int od = 0; od < 2; od++)
      for (int bad = 0; bad < 2; bad++) begin
        @(negedge clk); cfg_par = od ? 2'd3 : 2'd2;
        bitbang(9'h0B5, 8, 1, 1'(od), 1'(bad), 1);
        wait_rxc(); read_word(d, f, p);
        check(p === 1'(bad) && d === 9'h0B5, "R2 pe flag", p, bad);
      end

    // R1 short character via bit-bang: upper bits zero
    @(negedge clk); cfg_par = 2'd0; cfg_len = 3'd0;
    bitbang(9'h1F5, 5, 0, 0, 0, 1);
    wait_rxc(); read_word(d, f, p);
    check(d === 9'h015, "R1 upper bits zero", d, 9'h015);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule